// File: doc/BRIEF.md
# SD Host Transfer Block Counter

This block keeps the transfer-setup state of an SD host controller: a 32-bit command argument, a transfer-mode word and a 16-bit remaining-block count. Software programs these through a simple register write port and reads them back through a combinational read port. The data path reports each finished block with a one-cycle strobe. While block counting is enabled for a multi-block transfer, the block lowers the count by one for each strobe, holds the count at zero, and raises a stop flag that tells the data path to move no more blocks.

The data path also supplies the data-line inhibit status. While that status is high, writes to the mode word and the count are discarded, so a transfer in flight cannot be reprogrammed. A one-cycle completion pulse marks the step of the count from one to zero. To suspend a transfer, software reads the count, which gives the number of blocks still to move. To resume, it writes that value back.

Register addresses on the two-bit address: 0 is the argument, 1 is the mode word and 2 is the count. Address 3 reads as zero and ignores writes. In the mode word, bit 0 enables block counting and bit 1 selects a multi-block transfer.

Top module: `sd_xfer_setup`

## Requirements
- R1: After reset the count, the argument and the mode word read 0, and `xfer_done` is 0.
- R2: The 32-bit argument at address 0 takes every write, whatever the inhibit status, and reads back the value written.
- R3: When mode bits 0 and 1 are both set, each `blk_done` strobe lowers the count by exactly one. A strobe at a count of 0 leaves it at 0, with no wrap.
- R4: A transfer that starts with a count of 0 moves no blocks: `blk_stop` is high at once, strobes leave the count at 0, and no completion pulse appears.
- R5: When mode bit 0 or mode bit 1 is clear, `blk_done` strobes leave the count unchanged.
- R6: `xfer_done` is high for exactly one cycle, in the cycle after the strobe that takes the count from 1 to 0, and is low at all other times.
- R7: A write to the mode word (address 1) is ignored while `dat_inhibit` is 1.
- R8: A write to the count (address 2) is ignored while `dat_inhibit` is 1.
- R9: When a count write and an effective strobe arrive in the same cycle, the write is dropped and the decrement takes effect.
- R10: Reading address 2 returns the blocks still to move. A write of a saved value while `dat_inhibit` is 0 restores that value exactly.
- R11: `blk_stop` is 1 exactly when mode bits 0 and 1 are both set and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, zero-extended |
| blk_done | input | 1 | One-cycle strobe: a data block has finished |
| dat_inhibit | input | 1 | High while a data transaction holds the data lines |
| remaining | output | 16 | Current remaining-block count |
| xfer_done | output | 1 | One-cycle pulse when the count reaches zero |
| blk_stop | output | 1 | Counted multi-block transfer with nothing left to move |

## Verification
The main sweep covers all four combinations of the counting-enable and multi-block bits, with start counts from 0 to 5. Each start gets two more strobes than it has blocks, so one run shows a plain decrement, saturation at zero, and a count that must stay frozen. The start of 0 separates an empty transfer from a finished one. The mode combinations show that the strobe is ignored unless both bits are set.

Writes are issued with the inhibit high and low. One write is issued in the same cycle as a strobe, which separates the lock from the ordering of write and decrement. A save, overwrite and restore sequence checks that the count reads back intact.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  localparam int ARG_W  = 32;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 16;
  localparam int ADDR_W = 2;

  // Bit positions inside the mode word that the counter decodes.
  localparam int MODE_CNT_EN_BIT = 0;
  localparam int MODE_MULTI_BIT  = 1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ARG   = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Saturating step of the remaining-block count.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic             step);
    if (step && (cur != '0)) return cur - 1'b1;
    return cur;
  endfunction

  // A counted transfer needs both mode bits.
  function automatic logic counting_on(input logic [MODE_W-1:0] mode);
    return mode[MODE_CNT_EN_BIT] & mode[MODE_MULTI_BIT];
  endfunction

endpackage

// File: rtl/sdx_regfile.sv
module sdx_regfile
  import sdx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = ARG_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          dat_inhibit,
  input  logic          blk_done,
  output logic [DW-1:0] arg_q,
  output logic [MW-1:0] mode_q,
  output logic          cnt_load
);

  logic arg_we;
  logic mode_we;
  logic cnt_we_raw;

  assign arg_we     = wr_en && (wr_addr == SEL_ARG);
  assign mode_we    = wr_en && (wr_addr == SEL_MODE) && !dat_inhibit;
  assign cnt_we_raw = wr_en && (wr_addr == SEL_COUNT);
  // The count is locked out while the lines are held, and also when a
  // block finishes in the same cycle.
  assign cnt_load   = cnt_we_raw && !dat_inhibit && !blk_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0;
    end else if (arg_we) begin
      arg_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= wr_data[MW-1:0];
    end
  end

  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_inhibit |=> $stable(mode_q));

  assert_arg_takes_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_ARG) |=> (arg_q == $past(wr_data)));

endmodule

// File: rtl/sdx_blk_counter.sv
module sdx_blk_counter
  import sdx_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_on,
  input  logic          blk_done,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dat_inhibit,
  output logic [CW-1:0] cnt_q,
  output logic          done_q,
  output logic          stop
);

  logic dec_req;
  logic dec_fire;
  logic last_blk;

  assign dec_req  = blk_done && count_on;
  assign dec_fire = dec_req && (cnt_q != '0);
  assign last_blk = dec_fire && (cnt_q == CW'(1));
  assign stop     = count_on && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else begin
      cnt_q <= next_count(cnt_q, dec_req);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= last_blk;
    end
  end

  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && count_on && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  assert_strobe_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_on && !load) |=> $stable(cnt_q));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0 || $past(load)));

  assert_count_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_inhibit && !dec_fire) |=> $stable(cnt_q));

endmodule

// File: rtl/sd_xfer_setup.sv
module sd_xfer_setup
  import sdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ARG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ARG_W-1:0]  rd_data,
  input  logic              blk_done,
  input  logic              dat_inhibit,
  output logic [CNT_W-1:0]  remaining,
  output logic              xfer_done,
  output logic              blk_stop
);

  logic [ARG_W-1:0]  arg_q;
  logic [MODE_W-1:0] mode_q;
  logic              cnt_load;
  logic              count_on;

  sdx_regfile #(.AW(ADDR_W), .DW(ARG_W), .MW(MODE_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dat_inhibit (dat_inhibit),
    .blk_done    (blk_done),
    .arg_q       (arg_q),
    .mode_q      (mode_q),
    .cnt_load    (cnt_load)
  );

  assign count_on = counting_on(mode_q);

  sdx_blk_counter #(.CW(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_on    (count_on),
    .blk_done    (blk_done),
    .load        (cnt_load),
    .load_val    (wr_data[CNT_W-1:0]),
    .dat_inhibit (dat_inhibit),
    .cnt_q       (remaining),
    .done_q      (xfer_done),
    .stop        (blk_stop)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_ARG:   rd_data = arg_q;
      SEL_MODE:  rd_data = ARG_W'(mode_q);
      SEL_COUNT: rd_data = ARG_W'(remaining);
      default:   rd_data = '0;
    endcase
  end

  assert_stop_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stop |-> (mode_q[MODE_CNT_EN_BIT] && mode_q[MODE_MULTI_BIT] && remaining == '0));

  assert_write_vs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_COUNT && blk_done) |=> (remaining <= $past(remaining)));

endmodule

// File: tb/sd_xfer_setup_tb.sv
module sd_xfer_setup_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        blk_done = 1'b0;
  logic        dat_inhibit = 1'b0;
  logic [15:0] remaining;
  logic        xfer_done;
  logic        blk_stop;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_xfer_setup dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .blk_done(blk_done),
    .dat_inhibit(dat_inhibit), .remaining(remaining), .xfer_done(xfer_done),
    .blk_stop(blk_stop)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives at a falling edge, commits at the rising edge, returns at the next falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    blk_done = 1'b1;
    @(posedge clk); @(negedge clk);
    blk_done = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input longint exp);
    rd_addr = a; #1;
    check(req, "read", rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "remaining", remaining, 0);
    check("R1", "xfer_done", xfer_done, 0);
    rd_check("R1", 2'd0, 0);
    rd_check("R1", 2'd1, 0);

    // R2 argument, with inhibit high as well
    wr(2'd0, 32'hA5C3_0F1E);
    rd_check("R2", 2'd0, 32'hA5C3_0F1E);
    dat_inhibit = 1'b1;
    wr(2'd0, 32'h1234_5678);
    rd_check("R2", 2'd0, 32'h1234_5678);
    dat_inhibit = 1'b0;

    // Sweep: mode bit0 = count enable, bit1 = multi-block; R3 R4 R5 R6 R11
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 6; s++) begin
        int exp;
        bit on;
        on = (m == 3);
        exp = s;
        dat_inhibit = 1'b0;
        wr(2'd1, m);
        wr(2'd2, s);
        check("R11", "blk_stop at start", blk_stop, (on && s == 0));
        check("R4", "count at start", remaining, s);
        dat_inhibit = 1'b1;
        for (int k = 0; k < s + 2; k++) begin
          int prev;
          prev = exp;
          if (on && exp > 0) exp = exp - 1;
          strobe();
          check(on ? "R3" : "R5", "remaining", remaining, exp);
          check(s == 0 ? "R4" : "R6", "xfer_done", xfer_done, (on && prev == 1));
          check("R11", "blk_stop", blk_stop, (on && exp == 0));
        end
        @(negedge clk);
        check("R6", "xfer_done cleared", xfer_done, 0);
      end
    end

    // R7 mode lock
    dat_inhibit = 1'b0;
    wr(2'd1, 3);
    dat_inhibit = 1'b1;
    wr(2'd1, 0);
    rd_check("R7", 2'd1, 3);
    dat_inhibit = 1'b0;
    wr(2'd1, 1);
    rd_check("R7", 2'd1, 1);
    wr(2'd1, 3);

    // R8 count lock
    wr(2'd2, 9);
    dat_inhibit = 1'b1;
    wr(2'd2, 7);
    rd_check("R8", 2'd2, 9);
    dat_inhibit = 1'b0;

    // R9 write and strobe in the same cycle
    wr(2'd2, 5);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 2; blk_done = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; blk_done = 1'b0;
    check("R9", "remaining", remaining, 4);

    // R10 save, overwrite, restore
    dat_inhibit = 1'b1;
    strobe(); strobe();
    dat_inhibit = 1'b0;
    rd_check("R10", 2'd2, 2);
    wr(2'd2, 16'hFFFF);
    rd_check("R10", 2'd2, 16'hFFFF);
    wr(2'd2, 2);
    rd_check("R10", 2'd2, 2);
    rd_check("R10", 2'd3, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule